// File: doc/BRIEF.md
# Brown-Out Event Filter

This block sits between a brown-out detector and the processor and decides how a dip in supply is reported. A control register chooses one of three responses. The block can request a system reset, raise an interrupt straight away, or wait a programmable number of oscillator clocks and then look at the detector again. In the wait case, a detector pulse that has gone by the resample point is thrown away as noise.

The raw detector input passes through a two-stage synchronizer. A new event starts on a rising edge of the synchronized level. Interrupts are kept in a sticky status flag that drives the interrupt output until software clears it. Reset requests are one-clock pulses.

Software uses a small word-addressed register port:
- Address 0 is the control register.
- Address 1 is the read-only interrupt status.
- Address 2 is a write-only clear strobe.

Reads are combinational from the address.

Top module: `brownout_filter`

## Requirements
- R1: After reset, the control register at address 0 reads 0x00007FFD. Its fields are: bits 15:2 hold the delay count N (0x1FFF at reset), bit 1 is the reset-select flag (0 at reset), and bit 0 is the wait-enable flag (1 at reset). The interrupt status at address 1 reads 0, and both outputs are low.
- R2: Bits 31:16 of the control register always read as zero, and writes to them are ignored. For example, writing 0xFFFFFFFF reads back as 0x0000FFFF.
- R3: With reset-select = 1, a detector assertion produces a `resetReq` pulse exactly one clock wide. It is high in the cycle after the third rising clock edge, counting the first edge that sees the raw input high as the first.
- R4: With reset-select = 0 and wait-enable = 0, the interrupt status is set with the same three-edge latency as R3, with no resampling.
- R5: With reset-select = 0 and wait-enable = 1, the interrupt status is set N+2 edges after the first edge that sees the raw input high. This happens only if the raw input is still high at edge N of that count.
- R6: If the raw input is low at the resample point of R5, the assertion is discarded and nothing is reported.
- R7: While a wait is in progress, further edges on the input neither restart nor extend it. Only a rising edge after the resample decision starts a new event.
- R8: A programmed delay count of 0 behaves as a delay of 1.
- R9: The interrupt status reads at bit 0 of address 1 and drives `irqOut`. It stays set until a write with bit 0 = 1 to address 2. Writes to address 1 have no effect.
- R10: A single event never produces both a reset request and an interrupt. Events in reset mode leave the interrupt status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| bodRaw | input | 1 | Asynchronous brown-out detector level |
| resetReq | output | 1 | One-clock system reset request |
| irqOut | output | 1 | Interrupt request, the sticky status flag |

## Verification
The bench targets the resample boundary. It holds the input high for exactly N+1 edges, which must be reported, and for N edges, which must be dropped. A counter that is off by one in either direction would report the short pulse or lose the long one. It re-pulses the input during a wait: a design that restarts its count on each edge would move the interrupt late or raise two of them. It also covers a zero delay, the full default delay, and masking of the reserved bits. Every event is checked against its exact expected clock cycle, so a wrong synchronizer depth, or a reset raised together with an interrupt, shows up as a cycle or kind mismatch.

// File: rtl/bof_pkg.sv
package bof_pkg;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 2;
  parameter int DELAY_W = 14;

  localparam int CTRL_W = DELAY_W + 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(2);

  typedef struct packed {
    logic [DELAY_W-1:0] delay;
    logic               rstSel;
    logic               waitEn;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{delay: DELAY_W'(13'h1FFF), rstSel: 1'b0, waitEn: 1'b1};

  typedef struct packed {
    logic loadCnt;
    logic stepCnt;
    logic fireIrq;
    logic fireRst;
  } strobe_t;

  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
endpackage

// File: rtl/bof_control.sv
module bof_control
  import bof_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  ctrl_t   ctrlQ,
  input  logic    bodRise,
  input  logic    bodSync,
  input  logic    cntLast,
  output strobe_t stb
);
  state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (bodRise) begin
          if (ctrlQ.rstSel) begin
            stb.fireRst = 1'b1;
          end else if (!ctrlQ.waitEn) begin
            stb.fireIrq = 1'b1;
          end else begin
            stb.loadCnt = 1'b1;
            stateD      = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (cntLast) begin
          stb.fireIrq = bodSync;
          stateD      = ST_IDLE;
        end else begin
          stb.stepCnt = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/bof_datapath.sv
module bof_datapath
  import bof_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              bodRaw,
  input  strobe_t           stb,
  output ctrl_t             ctrlQ,
  output logic              bodSync,
  output logic              bodRise,
  output logic              cntLast,
  output logic              resetReq,
  output logic              irqOut
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   bodPrevQ;
  logic [DELAY_W-1:0]     cntQ;
  logic [DELAY_W-1:0]     loadVal;
  logic                   irqQ;
  logic                   rstQ;
  logic                   wrCtrl, wrClr;

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrClr  = regWrEn && (regAddr == ADDR_CLR) && regWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlQ <= CTRL_RESET;
    else if (wrCtrl) ctrlQ <= ctrl_t'(regWrData[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      bodPrevQ <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], bodRaw};
      bodPrevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign bodSync = syncQ[SYNC_STAGES-1];
  assign bodRise = bodSync && !bodPrevQ;

  assign loadVal = (ctrlQ.delay == '0) ? DELAY_W'(1) : ctrlQ.delay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (stb.loadCnt) cntQ <= loadVal;
    else if (stb.stepCnt) cntQ <= cntQ - DELAY_W'(1);
  end

  assign cntLast = (cntQ == DELAY_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
      rstQ <= 1'b0;
    end else begin
      rstQ <= stb.fireRst;
      if (stb.fireIrq)  irqQ <= 1'b1;
      else if (wrClr)   irqQ <= 1'b0;
    end
  end

  assign resetReq = rstQ;
  assign irqOut   = irqQ;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL)      regRdData[CTRL_W-1:0] = ctrlQ;
    else if (regAddr == ADDR_STAT) regRdData[0]          = irqQ;
  end
endmodule

// File: rtl/brownout_filter.sv
module brownout_filter
  import bof_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              bodRaw,
  output logic              resetReq,
  output logic              irqOut
);
  strobe_t stb;
  ctrl_t   ctrlQ;
  logic    bodSync, bodRise, cntLast;
  logic    rstSelQ;

  assign rstSelQ = ctrlQ.rstSel;

  bof_control ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .bodRise(bodRise),
    .bodSync(bodSync), .cntLast(cntLast), .stb(stb)
  );

  bof_datapath dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .bodRaw(bodRaw),
    .stb(stb), .ctrlQ(ctrlQ), .bodSync(bodSync), .bodRise(bodRise),
    .cntLast(cntLast), .resetReq(resetReq), .irqOut(irqOut)
  );
endmodule

// File: rtl/bof_checker.sv
module bof_checker
  import bof_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              resetReq,
  input logic              irqOut,
  input logic              rstSelQ
);
  assert_rst_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  assert_rst_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(rstSelQ));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && $rose(irqOut)));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(regWrEn && regAddr == ADDR_CLR && regWrData[0]));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CTRL) |-> (regRdData[DATA_W-1:CTRL_W] == '0));

  assert_status_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STAT) |-> (regRdData[0] == irqOut));
endmodule

bind brownout_filter bof_checker chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .resetReq(resetReq),
  .irqOut(irqOut), .rstSelQ(rstSelQ)
);

// File: tb/brownout_filter_tb_top.sv
module brownout_filter_tb_top;
  localparam int KIND_IRQ = 0;
  localparam int KIND_RST = 1;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        bodRaw = 1'b0;
  logic        resetReq, irqOut;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  logic prevIrq = 1'b0;
  exp_t expQ[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  brownout_filter dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .bodRaw(bodRaw),
    .resetReq(resetReq), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops the scoreboard on each reset pulse or interrupt rising edge
  task automatic observe(input int kind);
    exp_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R6/R7/R10 unexpected event", kind, -1);
    end else begin
      e = expQ.pop_front();
      check(e.kind == kind && e.cyc == cyc, e.req, {32'(kind), 32'(cyc)}, {32'(e.kind), 32'(e.cyc)});
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (resetReq)           observe(KIND_RST);
      if (irqOut && !prevIrq) observe(KIND_IRQ);
    end
    prevIrq = irqOut;
  end

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // Driver: raises the input for 'hold' edges and pushes the expected event
  task automatic pulse(input int hold, input bit expect_ev, input int kind,
                       input int lat, input string req);
    int k;
    exp_t e;
    k = cyc;
    if (expect_ev) begin
      e.kind = kind; e.cyc = k + lat; e.req = req;
      expQ.push_back(e);
    end
    bodRaw = 1'b1;
    repeat (hold) @(negedge clk);
    bodRaw = 1'b0;
  endtask

  task automatic drain(input int n, input string req);
    repeat (n) @(negedge clk);
    check(expQ.size() == 0, req, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic clearIrq(input string req);
    logic [31:0] d;
    writeReg(2'd2, 32'h1);
    readReg(2'd1, d);
    check(irqOut == 1'b0 && d == 32'h0, req, {irqOut, d[0]}, 0);
  endtask

  initial begin
    #4000000;
    check(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(2'd0, d); check(d == 32'h00007FFD, "R1 ctrl reset", d, 32'h7FFD);
    readReg(2'd1, d); check(d == 32'h0, "R1 status reset", d, 0);
    check(!irqOut && !resetReq, "R1 outputs reset", {irqOut, resetReq}, 0);

    // R2 reserved bits
    writeReg(2'd0, 32'hFFFF_FFFF);
    readReg(2'd0, d); check(d == 32'h0000FFFF, "R2 reserved masked", d, 32'hFFFF);

    // R3 reset mode, R10 no interrupt
    writeReg(2'd0, (32'd5 << 2) | 32'h2);
    pulse(4, 1, KIND_RST, 3, "R3 reset pulse timing");
    drain(12, "R3 reset event seen");
    readReg(2'd1, d); check(d == 32'h0 && !irqOut, "R10 no irq in reset mode", d, 0);

    // R4 immediate interrupt; R9 sticky and clear
    writeReg(2'd0, 32'd5 << 2);
    pulse(3, 1, KIND_IRQ, 3, "R4 immediate irq timing");
    drain(10, "R4 irq seen");
    writeReg(2'd1, 32'h0);
    readReg(2'd1, d); check(d == 32'h1 && irqOut, "R9 status sticky", d, 1);
    clearIrq("R9 clear");

    // R5 wait, boundary hold N+1 reported
    writeReg(2'd0, (32'd10 << 2) | 32'h1);
    pulse(11, 1, KIND_IRQ, 13, "R5 resample irq timing");
    drain(20, "R5 irq seen");
    clearIrq("R9 clear after R5");

    // R6 hold N rejected
    pulse(10, 0, KIND_IRQ, 0, "R6");
    drain(25, "R6 noise rejected");
    readReg(2'd1, d); check(d == 32'h0, "R6 status stays clear", d, 0);

    // R7 re-edges during wait ignored
    writeReg(2'd0, (32'd20 << 2) | 32'h1);
    begin
      int k;
      exp_t e;
      k = cyc;
      e.kind = KIND_IRQ; e.cyc = k + 23; e.req = "R7 no restart in wait";
      expQ.push_back(e);
      bodRaw = 1'b1; repeat (3) @(negedge clk);
      bodRaw = 1'b0; repeat (3) @(negedge clk);
      bodRaw = 1'b1; repeat (30) @(negedge clk);
      bodRaw = 1'b0;
    end
    drain(10, "R7 single irq");
    clearIrq("R9 clear after R7");
    pulse(22, 1, KIND_IRQ, 23, "R7 new event after decision");
    drain(30, "R7 second event seen");
    clearIrq("R9 clear after R7 second");

    // R8 zero delay acts as one
    writeReg(2'd0, 32'h1);
    pulse(2, 1, KIND_IRQ, 4, "R8 zero delay irq timing");
    drain(10, "R8 irq seen");
    clearIrq("R9 clear after R8");
    pulse(1, 0, KIND_IRQ, 0, "R8");
    drain(10, "R8 one-edge pulse rejected");

    // R5 full default delay
    writeReg(2'd0, 32'h00007FFD);
    pulse(8192, 1, KIND_IRQ, 3 + 8191, "R5 default delay timing");
    drain(20, "R5 default irq seen");
    clearIrq("R9 final clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule